// File: doc/BRIEF.md
# Branch Target and Fetch Fault Checker

This block sits between the execute and fetch stages of a 64-bit in-order core with 39-bit sign-extended virtual addresses. It checks address faults on control-transfer targets, and the checks are split by stage. On the execute side, a resolved control transfer that is taken and has a target that is not a multiple of four is faulted against the transferring instruction. That instruction does not retire and does not redirect. On the fetch side, every fetch address is tested for correct sign extension while translation is enabled. A failing fetch is charged to the fetch itself, so a transfer to a badly extended but aligned target still retires and redirects first. A return-from-trap is presented on the same execute interface as a taken transfer, so a bad return pc faults only at the following fetch.

Faults from both sides are merged into one prioritized record. The record holds a 4-bit cause, the faulting pc and the trap value. It is paired with a one-cycle flush pulse that squashes younger fetches. The record stays on the outputs until the core takes it with a valid/ready handshake. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `xfer_fault_unit`

## Requirements
- R1: After reset, excValid, flush, retire and redirect are all 0.
- R2: With vmEn=1, a valid fetch whose address bits 63..39 are not all equal to bit 38 produces a record with cause 12, excPc and excTval both equal to the fetch address. Fetch addresses with bits 63..38 all 0 or all 1 produce no record.
- R3: A valid, taken transfer whose target has bit 1 or bit 0 set produces a record with cause 0, excPc equal to xferPc and excTval equal to the target. In the same cycle, retire and redirect stay 0.
- R4: A valid, taken transfer with an aligned target retires (retire=1) and redirects (redirect=1, redirectPc equal to the target) one cycle later. It raises no record, even when the target is not sign-extended. This also holds for a return-from-trap presented as a taken transfer.
- R5: The causes are distinct 4-bit codes: 0 for a misaligned target, 1 for an access fault, 12 for a page fault. No other value is reported.
- R6: A taken target that is both misaligned and not sign-extended reports only cause 0 against the transfer.
- R7: A not-taken transfer never faults, whatever its target. It retires without redirecting.
- R8: With vmEn=0, no page fault is raised. A valid fetch with fetchAccFault=1 gives cause 1, with excPc and excTval equal to the fetch address.
- R9: When a fetch is both a page fault and flagged as an access fault, cause 12 is reported.
- R10: When an execute-side misalignment and a fetch-side fault arrive in the same cycle, the misalignment (cause 0, excPc equal to xferPc) is recorded.
- R11: flush is 1 only in the cycle in which a new record first appears, and is 0 in the following cycle unless another record is captured.
- R12: While excValid=1 and excReady=0, the record stays unchanged and further faults are dropped. A cycle with excValid=1 and excReady=1 and no new fault clears excValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferValid | input | 1 | A resolved control transfer is presented |
| xferTaken | input | 1 | The transfer is taken |
| xferPc | input | 64 | pc of the transferring instruction |
| xferTarget | input | 64 | Resolved target address |
| fetchValid | input | 1 | A fetch address is presented |
| fetchAddr | input | 64 | Fetch address |
| fetchAccFault | input | 1 | External access-fault flag for this fetch |
| vmEn | input | 1 | Address translation enabled |
| excReady | input | 1 | Core accepts the held record |
| excValid | output | 1 | Record valid |
| excCause | output | 4 | Exception cause code |
| excPc | output | 64 | pc charged with the exception |
| excTval | output | 64 | Trap value (offending address) |
| flush | output | 1 | One-cycle squash of younger fetches |
| retire | output | 1 | The presented transfer retired |
| redirect | output | 1 | Fetch is redirected |
| redirectPc | output | 64 | New fetch address |

## Verification
The embedded assertions check on every cycle the following properties:
- a flush never appears without a valid record;
- a held record is stable until it is acknowledged;
- only the three legal causes are ever reported;
- a misaligned taken transfer neither retires nor redirects;
- a not-taken transfer always retires without redirect;
- a page fault wins over a simultaneous access fault.

Only the directed scenarios can show that the fault moves to the fetch. A badly extended aligned target first retires and redirects, and only its later fetch faults. The scenarios also show the exact pc and trap value recorded, the vmEn gating, and the priority of execute over fetch.

// File: rtl/xfer_fault_pkg.sv
package xfer_fault_pkg;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_MISAL = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ACC   = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_PAGE  = 4'd12;

  typedef struct packed {
    logic capExec;    // load record from the execute side
    logic capFetch;   // load record from the fetch side
    logic fetchPage;  // fetch record is a page fault (else access)
    logic retire;     // transfer completes
    logic redirect;   // transfer steers fetch
  } strobe_t;
endpackage

// File: rtl/xfer_fault_dp.sv
module xfer_fault_dp
  import xfer_fault_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int VA_BITS    = 39,
  parameter int ALIGN_BITS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic               vmEn,
  input  logic [XLEN-1:0]    xferPc,
  input  logic [XLEN-1:0]    xferTarget,
  input  logic [XLEN-1:0]    fetchAddr,
  output logic               misAl,
  output logic               nonCanon,
  output logic [CAUSE_W-1:0] excCause,
  output logic [XLEN-1:0]    excPc,
  output logic [XLEN-1:0]    excTval,
  output logic [XLEN-1:0]    redirectPc
);
  localparam int UPPER_W = XLEN - VA_BITS + 1;

  assign misAl = |xferTarget[ALIGN_BITS-1:0];

  generate
    if (VA_BITS >= XLEN) begin : g_flat
      assign nonCanon = 1'b0;
    end else begin : g_ext
      logic [UPPER_W-1:0] upperBits;
      assign upperBits = fetchAddr[XLEN-1:VA_BITS-1];
      assign nonCanon  = !((&upperBits) || !(|upperBits));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excCause   <= '0;
      excPc      <= '0;
      excTval    <= '0;
      redirectPc <= '0;
    end else begin
      if (st.capExec) begin
        excCause <= CAUSE_MISAL;
        excPc    <= xferPc;
        excTval  <= xferTarget;
      end else if (st.capFetch) begin
        excCause <= st.fetchPage ? CAUSE_PAGE : CAUSE_ACC;
        excPc    <= fetchAddr;
        excTval  <= fetchAddr;
      end
      if (st.redirect) redirectPc <= xferTarget;
    end
  end

  AST_PAGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (st.capFetch && vmEn && nonCanon) |=> (excCause == CAUSE_PAGE)); // R9
  AST_MISAL_TVAL: assert property (@(posedge clk) disable iff (!rstN)
    st.capExec |=> (excTval[ALIGN_BITS-1:0] != '0)); // R3
endmodule

// File: rtl/xfer_fault_ctrl.sv
module xfer_fault_ctrl
  import xfer_fault_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    xferValid,
  input  logic    xferTaken,
  input  logic    misAl,
  input  logic    fetchValid,
  input  logic    fetchAccFault,
  input  logic    nonCanon,
  input  logic    vmEn,
  input  logic    excReady,
  output strobe_t st,
  output logic    excValid,
  output logic    flush,
  output logic    retire,
  output logic    redirect
);
  logic slotFree, execFault, pageFault, fetchFault, capAny;

  always_comb begin
    slotFree    = !excValid || excReady;
    execFault   = xferValid && xferTaken && misAl;
    pageFault   = fetchValid && vmEn && nonCanon;
    fetchFault  = pageFault || (fetchValid && fetchAccFault);
    st.capExec  = slotFree && execFault;
    st.capFetch = slotFree && !execFault && fetchFault;
    st.fetchPage = pageFault;
    st.retire   = xferValid && !execFault;
    st.redirect = xferValid && xferTaken && !execFault;
    capAny      = st.capExec || st.capFetch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid <= 1'b0;
      flush    <= 1'b0;
      retire   <= 1'b0;
      redirect <= 1'b0;
    end else begin
      if (capAny)        excValid <= 1'b1;
      else if (excReady) excValid <= 1'b0;
      flush    <= capAny;
      retire   <= st.retire;
      redirect <= st.redirect;
    end
  end

  AST_FLUSH_HAS_REC: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> excValid); // R11
  AST_MISAL_NO_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferTaken && misAl) |=> (!retire && !redirect)); // R3
  AST_NOT_TAKEN_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !xferTaken) |=> (retire && !redirect)); // R7
  AST_REDIRECT_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> retire); // R4
endmodule

// File: rtl/xfer_fault_unit.sv
module xfer_fault_unit
  import xfer_fault_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int VA_BITS    = 39,
  parameter int ALIGN_BITS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xferValid,
  input  logic               xferTaken,
  input  logic [XLEN-1:0]    xferPc,
  input  logic [XLEN-1:0]    xferTarget,
  input  logic               fetchValid,
  input  logic [XLEN-1:0]    fetchAddr,
  input  logic               fetchAccFault,
  input  logic               vmEn,
  input  logic               excReady,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic [XLEN-1:0]    excPc,
  output logic [XLEN-1:0]    excTval,
  output logic               flush,
  output logic               retire,
  output logic               redirect,
  output logic [XLEN-1:0]    redirectPc
);
  strobe_t st;
  logic    misAl, nonCanon;

  xfer_fault_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferTaken(xferTaken),
    .misAl(misAl), .fetchValid(fetchValid), .fetchAccFault(fetchAccFault),
    .nonCanon(nonCanon), .vmEn(vmEn), .excReady(excReady), .st(st),
    .excValid(excValid), .flush(flush), .retire(retire), .redirect(redirect)
  );

  xfer_fault_dp #(.XLEN(XLEN), .VA_BITS(VA_BITS), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .vmEn(vmEn), .xferPc(xferPc),
    .xferTarget(xferTarget), .fetchAddr(fetchAddr), .misAl(misAl),
    .nonCanon(nonCanon), .excCause(excCause), .excPc(excPc),
    .excTval(excTval), .redirectPc(redirectPc)
  );

  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !excReady) |=> (excValid && $stable(excCause) &&
                                 $stable(excPc) && $stable(excTval))); // R12
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excCause == CAUSE_MISAL || excCause == CAUSE_ACC ||
                  excCause == CAUSE_PAGE)); // R5
endmodule

// File: tb/tb_xfer_fault_unit.sv
`timescale 1ns/1ps
module tb_xfer_fault_unit;
  logic        clk = 0, rstN = 0;
  logic        xferValid = 0, xferTaken = 0, fetchValid = 0, fetchAccFault = 0;
  logic        vmEn = 1, excReady = 0;
  logic [63:0] xferPc = 0, xferTarget = 0, fetchAddr = 0;
  logic        excValid, flush, retire, redirect;
  logic [3:0]  excCause;
  logic [63:0] excPc, excTval, redirectPc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xfer_fault_unit dut (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferTaken(xferTaken),
    .xferPc(xferPc), .xferTarget(xferTarget), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .fetchAccFault(fetchAccFault), .vmEn(vmEn),
    .excReady(excReady), .excValid(excValid), .excCause(excCause),
    .excPc(excPc), .excTval(excTval), .flush(flush), .retire(retire),
    .redirect(redirect), .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    xferValid = 0; xferTaken = 0; fetchValid = 0; fetchAccFault = 0; excReady = 0;
  endtask

  task automatic ack();
    idle(); excReady = 1; step(); excReady = 0;
    chk("R12 cleared by ack", excValid, 0);
  endtask

  task automatic xfer(input logic tk, input logic [63:0] pc, input logic [63:0] tgt);
    xferValid = 1; xferTaken = tk; xferPc = pc; xferTarget = tgt;
  endtask

  task automatic fetch(input logic [63:0] a, input logic acc);
    fetchValid = 1; fetchAddr = a; fetchAccFault = acc;
  endtask

  task automatic t_reset();
    chk("R1 excValid", excValid, 0); chk("R1 flush", flush, 0);
    chk("R1 retire", retire, 0);     chk("R1 redirect", redirect, 0);
  endtask

  task automatic t_page_and_hold();
    vmEn = 1; fetch(64'h0000_0080_0000_0000, 0); step(); idle();
    chk("R2 valid", excValid, 1); chk("R2 cause", excCause, 12);
    chk("R2 pc", excPc, 64'h0000_0080_0000_0000);
    chk("R2 tval", excTval, 64'h0000_0080_0000_0000);
    chk("R11 flush pulse", flush, 1);
    fetch(64'h1234, 1); step(); idle();
    chk("R11 flush drops", flush, 0);
    chk("R12 held cause", excCause, 12);
    chk("R12 held pc", excPc, 64'h0000_0080_0000_0000);
    ack();
  endtask

  task automatic t_canon();
    fetch(64'hFFFF_FFC0_0000_1000, 0); step(); idle();
    chk("R2 upper canonical", excValid, 0);
    fetch(64'h0000_003F_FFFF_FFFC, 0); step(); idle();
    chk("R2 lower canonical", excValid, 0);
  endtask

  task automatic t_misal();
    xfer(1, 64'h1000, 64'h2002); step(); idle();
    chk("R3 cause", excCause, 0); chk("R3 pc", excPc, 64'h1000);
    chk("R3 tval", excTval, 64'h2002); chk("R3 retire", retire, 0);
    chk("R3 redirect", redirect, 0); chk("R3 valid", excValid, 1);
    ack();
  endtask

  task automatic t_retire_then_fault();
    xfer(1, 64'h4000, 64'h0001_0000_0000_0000); step(); idle();
    chk("R4 retire", retire, 1); chk("R4 redirect", redirect, 1);
    chk("R4 redirectPc", redirectPc, 64'h0001_0000_0000_0000);
    chk("R4 no fault at transfer", excValid, 0);
    fetch(redirectPc, 0); step(); idle();
    chk("R4 fault at fetch", excCause, 12);
    chk("R4 fault pc is target", excPc, 64'h0001_0000_0000_0000);
    ack();
  endtask

  task automatic t_both();
    xfer(1, 64'h5000, 64'h8000_0000_0000_0006); step(); idle();
    chk("R6 cause", excCause, 0); chk("R6 pc", excPc, 64'h5000);
    chk("R6 no retire", retire, 0);
    ack();
  endtask

  task automatic t_not_taken();
    xfer(0, 64'h6000, 64'h3); step(); idle();
    chk("R7 no record", excValid, 0); chk("R7 retire", retire, 1);
    chk("R7 no redirect", redirect, 0);
  endtask

  task automatic t_vm_off();
    vmEn = 0; fetch(64'h0000_0080_0000_0000, 0); step(); idle();
    chk("R8 no page fault", excValid, 0);
    fetch(64'h0000_0080_0000_0040, 1); step(); idle();
    chk("R8 access cause", excCause, 1);
    chk("R8 access tval", excTval, 64'h0000_0080_0000_0040);
    chk("R5 distinct access code", excValid, 1);
    ack(); vmEn = 1;
  endtask

  task automatic t_page_over_acc();
    fetch(64'h7FFF_0000_0000_0000, 1); step(); idle();
    chk("R9 page wins", excCause, 12);
    ack();
  endtask

  task automatic t_exec_over_fetch();
    xfer(1, 64'h9000, 64'h9001); fetch(64'h0000_0080_0000_0000, 0); step(); idle();
    chk("R10 cause", excCause, 0); chk("R10 pc", excPc, 64'h9000);
    ack();
  endtask

  initial begin
    @(negedge clk); @(negedge clk); rstN = 1; @(negedge clk);
    t_reset();
    t_page_and_hold();
    t_canon();
    t_misal();
    t_retire_then_fault();
    t_both();
    t_not_taken();
    t_vm_off();
    t_page_over_acc();
    t_exec_over_fetch();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule